// File: doc/BRIEF.md
# Receive Queue Threshold and Idle Timeout Monitor

This block sits beside a 16-entry receive queue of a serial port and watches its occupancy and traffic. It reports two conditions to the interrupt logic. The first, data-available, says that the number of stored bytes has reached a threshold chosen by a two-bit select. The second, character timeout, says that bytes are waiting in the queue but nothing has entered or left it for four character times.

The queue itself supplies its byte count and one-cycle push and pop strobes. A separate timing unit supplies a one-cycle pulse once per character time for the current line format. When queueing is switched off, the block acts like a single holding register: any stored byte counts as available, and the timeout never fires.

Top module: `rxqMonitor`

## Requirements
- R1: With `fifoEn` high, `trigSel` picks the threshold: 0 gives 1 byte, 1 gives 4, 2 gives 8 and 3 gives 14. `dataAvail` is high in the same cycle whenever `fifoCount` is greater than or equal to the threshold.
- R2: `dataAvail` is low in the same cycle whenever `fifoCount` is below the selected threshold, including right after a drop in the count.
- R3: With `fifoEn` low, the threshold is 1 for every value of `trigSel`.
- R4: With `fifoEn` high and `fifoCount` at least 1, `charTimeout` goes high in the cycle after the clock edge that samples the fourth `charTick` pulse with no `pushStb` or `popStb` since the last restart.
- R5: A clock edge that samples `pushStb` or `popStb` restarts the idle count at zero, and `charTimeout` is low after that edge. This holds even when `charTick` is high in the same cycle.
- R6: A clock edge that samples `fifoCount` equal to 0 holds the idle count at zero. `charTick` pulses seen while the queue is empty do not count.
- R7: With `fifoEn` low, the idle count is held at zero and `charTimeout` never goes high.
- R8: Three or fewer idle ticks do not raise `charTimeout`. Once it is high, it stays high through further ticks until a restart condition from R5 to R7 occurs.
- R9: While `rstN` is low, `charTimeout` is low and the idle count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| fifoCount | input | 5 | Number of bytes now in the receive queue (0 to 16) |
| pushStb | input | 1 | One-cycle strobe: a byte entered the queue |
| popStb | input | 1 | One-cycle strobe: a byte was read from the queue |
| trigSel | input | 2 | Threshold select (1, 4, 8 or 14 bytes) |
| fifoEn | input | 1 | Queue mode enable |
| charTick | input | 1 | One-cycle pulse per character time |
| dataAvail | output | 1 | Byte count has reached the threshold |
| charTimeout | output | 1 | Bytes are waiting and the queue has been idle for four character times |

## Verification
The bench looks for off-by-one errors at each threshold by stepping the count one byte at a time across every table entry. A wrong compare would show `dataAvail` one byte early or one byte late. It sends exactly three idle ticks and then a fourth, to catch a timer that fires a tick early or late. It places a pop in the same cycle as a tick, where a design that lets the tick win would still raise the timeout. It also sends ticks while the queue is empty and while queueing is off. A timer that is not held there would raise a false timeout as soon as a byte lands, or would fire in holding-register mode.

// File: rtl/rxqMonPkg.sv
package rxqMonPkg;

  // Strobes sent from the control to the datapath once per cycle
  typedef struct packed {
    logic timerClear;    // restart the idle counter at zero
    logic timerAdvance;  // count one idle character time
  } tmrCtl_t;

  // Threshold table, indexed by the two-bit select
  function automatic int unsigned selToThreshold(input logic [1:0] sel);
    case (sel)
      2'd0:    return 1;
      2'd1:    return 4;
      2'd2:    return 8;
      default: return 14;
    endcase
  endfunction

endpackage

// File: rtl/rxqMonCtrl.sv
module rxqMonCtrl
  import rxqMonPkg::*;
(
  input  logic    fifoEn,
  input  logic    pushStb,
  input  logic    popStb,
  input  logic    charTick,
  input  logic    queueEmpty,
  input  logic    timerFull,
  output tmrCtl_t tmrCtl
);

  always_comb begin
    // Any restart condition wins over a tick in the same cycle
    tmrCtl.timerClear   = !fifoEn || queueEmpty || pushStb || popStb;
    tmrCtl.timerAdvance = charTick && !timerFull && !tmrCtl.timerClear;
  end

endmodule

// File: rtl/rxqMonDatapath.sv
module rxqMonDatapath
  import rxqMonPkg::*;
#(
  parameter int CNT_W      = 5,
  parameter int IDLE_CHARS = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] fifoCount,
  input  logic [1:0]       trigSel,
  input  logic             fifoEn,
  input  tmrCtl_t          tmrCtl,
  output logic             queueEmpty,
  output logic             timerFull,
  output logic             dataAvail
);

  localparam int TMR_W = $clog2(IDLE_CHARS + 1);
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(IDLE_CHARS);

  logic [CNT_W-1:0] threshold;
  logic [TMR_W-1:0] idleCnt;

  // In holding-register mode a single byte is enough
  always_comb begin
    if (fifoEn) threshold = CNT_W'(selToThreshold(trigSel));
    else        threshold = CNT_W'(1);
  end

  assign queueEmpty = (fifoCount == '0);
  assign dataAvail  = (fifoCount >= threshold);
  assign timerFull  = (idleCnt == TMR_LAST);

  // The counter saturates at IDLE_CHARS
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   idleCnt <= '0;
    else if (tmrCtl.timerClear)  idleCnt <= '0;
    else if (tmrCtl.timerAdvance) idleCnt <= idleCnt + TMR_W'(1);
  end

endmodule

// File: rtl/rxqMonitor.sv
module rxqMonitor
  import rxqMonPkg::*;
#(
  parameter int DEPTH      = 16,
  parameter int IDLE_CHARS = 4,
  localparam int CNT_W     = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] fifoCount,
  input  logic             pushStb,
  input  logic             popStb,
  input  logic [1:0]       trigSel,
  input  logic             fifoEn,
  input  logic             charTick,
  output logic             dataAvail,
  output logic             charTimeout
);

  tmrCtl_t tmrCtl;
  logic    queueEmpty;
  logic    timerFull;

  rxqMonCtrl u_ctrl (
    .fifoEn     (fifoEn),
    .pushStb    (pushStb),
    .popStb     (popStb),
    .charTick   (charTick),
    .queueEmpty (queueEmpty),
    .timerFull  (timerFull),
    .tmrCtl     (tmrCtl)
  );

  rxqMonDatapath #(
    .CNT_W      (CNT_W),
    .IDLE_CHARS (IDLE_CHARS)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .fifoCount  (fifoCount),
    .trigSel    (trigSel),
    .fifoEn     (fifoEn),
    .tmrCtl     (tmrCtl),
    .queueEmpty (queueEmpty),
    .timerFull  (timerFull),
    .dataAvail  (dataAvail)
  );

  assign charTimeout = timerFull;

endmodule

// File: rtl/rxqMonChecker.sv
module rxqMonChecker #(
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic [CNT_W-1:0] fifoCount,
  input logic             pushStb,
  input logic             popStb,
  input logic             fifoEn,
  input logic             charTick,
  input logic             dataAvail,
  input logic             charTimeout
);

  // R1: the threshold is never below one byte
  a_r1_avail_needs_data: assert property (@(posedge clk) disable iff (!rstN)
    dataAvail |-> (fifoCount != '0));

  // R3: holding-register mode means any byte is available
  a_r3_single_byte_mode: assert property (@(posedge clk) disable iff (!rstN)
    !fifoEn |-> (dataAvail == (fifoCount != '0)));

  a_r4_rise_after_tick: assert property (@(posedge clk) disable iff (!rstN)
    $rose(charTimeout) |-> $past(charTick));

  a_r5_activity_clears: assert property (@(posedge clk) disable iff (!rstN)
    (pushStb || popStb) |=> !charTimeout);

  a_r6_empty_no_timeout: assert property (@(posedge clk) disable iff (!rstN)
    (fifoCount == '0) |=> !charTimeout);

  a_r7_disabled_no_timeout: assert property (@(posedge clk) disable iff (!rstN)
    !fifoEn |=> !charTimeout);

  a_r8_timeout_holds: assert property (@(posedge clk) disable iff (!rstN)
    (charTimeout && fifoEn && fifoCount != '0 && !pushStb && !popStb) |=> charTimeout);

endmodule

bind rxqMonitor rxqMonChecker #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .fifoCount   (fifoCount),
  .pushStb     (pushStb),
  .popStb      (popStb),
  .fifoEn      (fifoEn),
  .charTick    (charTick),
  .dataAvail   (dataAvail),
  .charTimeout (charTimeout)
);

// File: tb/rxqMonitor_tb.sv
`timescale 1ns/1ps
module rxqMonitor_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [4:0] fifoCount = '0;
  logic       pushStb = 1'b0;
  logic       popStb = 1'b0;
  logic [1:0] trigSel = '0;
  logic       fifoEn = 1'b1;
  logic       charTick = 1'b0;
  logic       dataAvail;
  logic       charTimeout;

  int nChecks = 0;
  int nFails = 0;
  int refIdle = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  rxqMonitor u_dut (
    .clk(clk), .rstN(rstN), .fifoCount(fifoCount), .pushStb(pushStb),
    .popStb(popStb), .trigSel(trigSel), .fifoEn(fifoEn), .charTick(charTick),
    .dataAvail(dataAvail), .charTimeout(charTimeout)
  );

  function automatic int expThreshold(bit en, logic [1:0] sel);
    if (!en) return 1;
    case (sel)
      2'd0: return 1;
      2'd1: return 4;
      2'd2: return 8;
      default: return 14;
    endcase
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // Drive one cycle starting just after a falling edge, check, then advance the model.
  task automatic cycle(int cnt, bit push, bit pop, logic [1:0] sel, bit en, bit tick, string tTag);
    int thr;
    bit expAvail;
    string aTag;
    fifoCount = 5'(cnt); pushStb = push; popStb = pop;
    trigSel = sel; fifoEn = en; charTick = tick;
    #1;
    thr = expThreshold(en, sel);
    expAvail = (cnt >= thr);
    aTag = !en ? "R3" : (expAvail ? "R1" : "R2");
    check(dataAvail == expAvail, aTag, int'(dataAvail), int'(expAvail));
    check(charTimeout == (refIdle == 4), tTag, int'(charTimeout), int'(refIdle == 4));
    @(posedge clk);
    if (!en || cnt == 0 || push || pop) refIdle = 0;
    else if (tick && refIdle < 4) refIdle++;
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    nFails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    if (!finished) begin
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int cnt;
    void'($urandom(32'h5eed_1234));
    // R9: reset state, ticks during reset are ignored
    fifoCount = 5'd3; charTick = 1'b1;
    repeat (3) @(negedge clk);
    check(charTimeout == 1'b0, "R9", int'(charTimeout), 0);
    charTick = 1'b0;
    rstN = 1'b1;
    @(negedge clk);

    // R1/R2: sweep count across every threshold
    for (int s = 0; s < 4; s++)
      for (int c = 0; c <= 16; c++) cycle(c, 1'b1, 1'b0, 2'(s), 1'b1, 1'b0, "R5");
    for (int c = 16; c >= 0; c--) cycle(c, 1'b0, 1'b1, 2'd3, 1'b1, 1'b0, "R5");
    // R3: disabled mode, all selects
    for (int s = 0; s < 4; s++)
      for (int c = 0; c <= 3; c++) cycle(c, 1'b0, 1'b0, 2'(s), 1'b0, 1'b1, "R7");

    // R8: three ticks give no timeout, R4: the fourth does
    for (int i = 0; i < 3; i++) begin cycle(2, 0, 0, 0, 1, 1, "R8"); cycle(2, 0, 0, 0, 1, 0, "R8"); end
    cycle(2, 0, 0, 0, 1, 0, "R8");
    cycle(2, 0, 0, 0, 1, 1, "R8");
    cycle(2, 0, 0, 0, 1, 0, "R4");
    check(charTimeout == 1'b1, "R4", int'(charTimeout), 1);
    for (int i = 0; i < 3; i++) cycle(2, 0, 0, 0, 1, 1, "R8");
    // R5: pop together with a tick still clears
    cycle(2, 0, 1, 0, 1, 1, "R5");
    cycle(1, 0, 0, 0, 1, 0, "R5");
    check(charTimeout == 1'b0, "R5", int'(charTimeout), 0);
    // R6: ticks while empty do not count
    for (int i = 0; i < 6; i++) cycle(0, 0, 0, 0, 1, 1, "R6");
    cycle(1, 1, 0, 0, 1, 1, "R6");
    for (int i = 0; i < 3; i++) cycle(1, 0, 0, 0, 1, 1, "R6");
    cycle(1, 0, 0, 0, 1, 0, "R6");
    check(charTimeout == 1'b0, "R6", int'(charTimeout), 0);
    // R7: disabled mode with many ticks and data waiting
    for (int i = 0; i < 8; i++) cycle(5, 0, 0, 1, 0, 1, "R7");
    cycle(5, 0, 0, 1, 0, 0, "R7");
    check(charTimeout == 1'b0, "R7", int'(charTimeout), 0);

    // Constrained random traffic
    cnt = 0;
    for (int i = 0; i < 4000; i++) begin
      bit push, pop, tick, en;
      logic [1:0] sel;
      push = ($urandom_range(0, 19) == 0) && cnt < 16;
      pop  = ($urandom_range(0, 24) == 0) && cnt > 0;
      tick = ($urandom_range(0, 2) == 0);
      en   = ($urandom_range(0, 49) != 0);
      sel  = (i % 500 == 0) ? 2'($urandom_range(0, 3)) : trigSel;
      cycle(cnt, push, pop, sel, en, tick, "R4");
      cnt = cnt + int'(push) - int'(pop);
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule